// File: doc/BRIEF.md
# Multiply-Accumulate Operand Sequencer

This block executes the three multiply-accumulate instructions of a 16-bit signal processor. On each accepted instruction it first folds the signed product of the X and Y operand registers it already holds into a 32-bit accumulator. Depending on the opcode, the product is added, subtracted, or the accumulator is cleared. It then fetches a fresh X and Y pair through two independent pointer banks. The new operands therefore feed only the following instruction, so a chain of these instructions runs a dot product with the fetch of pair n+1 overlapped with the use of pair n.

The block holds the X, Y and accumulator registers and the zero and negative flags. Pointer storage, post-modify arithmetic and the lower part of the status register sit outside. The block drives one request per bank, carrying a 5-bit selector, in the same cycle. Each bank may answer in any later cycle while the instruction is in progress. The operand registers are written only once both answers are in.

The control is a three-state machine:
- **IDLE**: waits for an instruction. IDLE goes to ISSUE on an accepted opcode.
- **ISSUE**: presents both requests for one cycle. ISSUE goes back to IDLE if both answers are captured, and to WAIT otherwise.
- **WAIT**: collects the remaining answers. WAIT goes to IDLE once both answers are held.

Top module: `mac_operand_seq`

## Requirements
- R1: Opcode field `instr_word[15:9]` = 0x4B (accumulate) sets `acc_out` to its old value plus the signed 16x16 product of the X and Y held before the instruction, modulo 2^32. `acc_out` changes only at the accepting edge.
- R2: Opcode field 0x1B (subtract) sets `acc_out` to its old value minus that same product, modulo 2^32.
- R3: Opcode field 0x5B (load) sets `acc_out` to 0 and clears `flag_z` and `flag_n`. It raises `stat_hi_clr` for exactly the one cycle after the accepting edge, telling the external status register to keep only its low 12 bits.
- R4: After accumulate or subtract, `flag_z` is 1 exactly when the new `acc_out` is 0, and `flag_n` equals bit 31 of the new `acc_out`.
- R5: `req_x_valid` and `req_y_valid` are high together for exactly the one cycle after the accepting edge. The X selector is `{instr[3:2], 1'b0, instr[1:0]}` and the Y selector is `{instr[7:6], 1'b1, instr[5:4]}`. Bit 2 is the bank offset, bits [4:3] carry the modifier and bits [1:0] the pointer index.
- R6: A response counts only while `busy` is high. It may arrive in the request cycle or any later cycle, and each bank's arrival is independent. `x_out` and `y_out` both take their response data at the edge where the later of the two responses is captured, and not before.
- R7: `busy` rises at the accepting edge and falls at the same edge at which `x_out` and `y_out` are written.
- R8: If `instr[8]` is 0 on an accepted instruction, `anomaly` is high for the one cycle after the accepting edge. The instruction still executes normally.
- R9: `instr_valid` is ignored while `busy` is high. Any opcode field other than 0x4B, 0x1B or 0x5B is ignored: `busy` stays low and `acc_out` is unchanged.
- R10: After reset, `acc_out`, `x_out`, `y_out`, `flag_z`, `flag_n`, `busy`, `anomaly`, `stat_hi_clr` and both request valids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present on `instr_word` |
| instr_word | input | 16 | Instruction word |
| busy | output | 1 | Instruction in progress |
| anomaly | output | 1 | Bit 8 was clear on the accepted instruction (one-cycle pulse) |
| stat_hi_clr | output | 1 | Clear the top status bits (one-cycle pulse, load form) |
| req_x_valid | output | 1 | X pointer-bank read request |
| req_x_sel | output | 5 | X request selector |
| rsp_x_valid | input | 1 | X read data valid |
| rsp_x_data | input | 16 | X read data |
| req_y_valid | output | 1 | Y pointer-bank read request |
| req_y_sel | output | 5 | Y request selector |
| rsp_y_valid | input | 1 | Y read data valid |
| rsp_y_data | input | 16 | Y read data |
| x_out | output | 16 | X operand register |
| y_out | output | 16 | Y operand register |
| acc_out | output | 32 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The assertions check, on every cycle, the following ordering rules:
- The accumulator moves only at an accepting edge, and no instruction starts while one is in progress.
- The two requests are paired single-cycle pulses.
- The operand registers move only as `busy` falls.
- The flags agree with the new accumulator after accumulate and subtract, and a load leaves a zero accumulator with both flags clear.
- An anomaly pulse appears only at the start of an instruction.

Only the directed scenarios can show the arithmetic values:
- the product of the previous operands, including sign extremes, wrap and an exact zero result;
- the selector bit placement;
- the response data landing in the right register under staggered and simultaneous bank latencies.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_ACC,
        KIND_SUB,
        KIND_LOAD
    } mac_kind_t;

    localparam int OPC_W = 7;
    localparam logic [OPC_W-1:0] OPC_ACC  = 7'h4B;
    localparam logic [OPC_W-1:0] OPC_SUB  = 7'h1B;
    localparam logic [OPC_W-1:0] OPC_LOAD = 7'h5B;

    function automatic mac_kind_t decode_kind(input logic [OPC_W-1:0] opc);
        mac_kind_t k;
        unique case (opc)
            OPC_ACC:  k = KIND_ACC;
            OPC_SUB:  k = KIND_SUB;
            OPC_LOAD: k = KIND_LOAD;
            default:  k = KIND_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/mac_arith.sv
module mac_arith
    import mac_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 2 * DATA_W
) (
    input  mac_kind_t          kind,
    input  logic [ACC_W-1:0]   acc_cur,
    input  logic [DATA_W-1:0]  x_cur,
    input  logic [DATA_W-1:0]  y_cur,
    output logic [ACC_W-1:0]   acc_nxt,
    output logic               z_nxt,
    output logic               n_nxt
);
    localparam int EXT_W = ACC_W - DATA_W;

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] y_ext;
    logic [ACC_W-1:0]        prod;

    always_comb begin
        x_ext = {{EXT_W{x_cur[DATA_W-1]}}, x_cur};
        y_ext = {{EXT_W{y_cur[DATA_W-1]}}, y_cur};
        prod  = x_ext * y_ext;
    end

    always_comb begin
        unique case (kind)
            KIND_ACC: acc_nxt = acc_cur + prod;
            KIND_SUB: acc_nxt = acc_cur - prod;
            default:  acc_nxt = '0;
        endcase
        if (kind == KIND_LOAD) begin
            z_nxt = 1'b0;
            n_nxt = 1'b0;
        end else begin
            z_nxt = (acc_nxt == '0);
            n_nxt = acc_nxt[ACC_W-1];
        end
    end
endmodule

// File: rtl/operand_catch.sv
module operand_catch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              listen,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              have,
    output logic [DATA_W-1:0] value
);
    logic              got_q;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        have  = listen && (got_q || rsp_valid);
        value = got_q ? hold_q : rsp_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            got_q  <= 1'b0;
            hold_q <= '0;
        end else if (arm) begin
            got_q  <= 1'b0;
        end else if (listen && rsp_valid && !got_q) begin
            got_q  <= 1'b1;
            hold_q <= rsp_data;
        end
    end
endmodule

// File: rtl/mac_operand_seq.sv
module mac_operand_seq
    import mac_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    output logic              busy,
    output logic              anomaly,
    output logic              stat_hi_clr,
    output logic              req_x_valid,
    output logic [4:0]        req_x_sel,
    input  logic              rsp_x_valid,
    input  logic [DATA_W-1:0] rsp_x_data,
    output logic              req_y_valid,
    output logic [4:0]        req_y_sel,
    input  logic              rsp_y_valid,
    input  logic [DATA_W-1:0] rsp_y_data,
    output logic [DATA_W-1:0] x_out,
    output logic [DATA_W-1:0] y_out,
    output logic [ACC_W-1:0]  acc_out,
    output logic              flag_z,
    output logic              flag_n
);
    localparam int OPC_LSB = 9;
    localparam int CHK_BIT = 8;

    seq_state_t state_q, state_d;
    mac_kind_t  kind;
    logic       accept;
    logic       listen;
    logic       x_have, y_have, both_in;
    logic [DATA_W-1:0] x_new, y_new;
    logic [ACC_W-1:0]  acc_nxt;
    logic              z_nxt, n_nxt;

    always_comb begin
        kind   = decode_kind(instr_word[15:OPC_LSB]);
        accept = (state_q == ST_IDLE) && instr_valid && (kind != KIND_NONE);
        listen = (state_q != ST_IDLE);
        both_in = x_have && y_have;
    end

    mac_arith #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_arith (
        .kind    (kind),
        .acc_cur (acc_out),
        .x_cur   (x_out),
        .y_cur   (y_out),
        .acc_nxt (acc_nxt),
        .z_nxt   (z_nxt),
        .n_nxt   (n_nxt)
    );

    operand_catch #(.DATA_W(DATA_W)) u_catch_x (
        .clk (clk), .rst_n (rst_n), .arm (accept), .listen (listen),
        .rsp_valid (rsp_x_valid), .rsp_data (rsp_x_data),
        .have (x_have), .value (x_new)
    );

    operand_catch #(.DATA_W(DATA_W)) u_catch_y (
        .clk (clk), .rst_n (rst_n), .arm (accept), .listen (listen),
        .rsp_valid (rsp_y_valid), .rsp_data (rsp_y_data),
        .have (y_have), .value (y_new)
    );

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)  state_d = ST_ISSUE;
            ST_ISSUE: state_d = both_in ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (both_in) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            anomaly     <= 1'b0;
            stat_hi_clr <= 1'b0;
            req_x_valid <= 1'b0;
            req_y_valid <= 1'b0;
            req_x_sel   <= '0;
            req_y_sel   <= '0;
            x_out       <= '0;
            y_out       <= '0;
            acc_out     <= '0;
            flag_z      <= 1'b0;
            flag_n      <= 1'b0;
        end else begin
            anomaly     <= accept && !instr_word[CHK_BIT];
            stat_hi_clr <= accept && (kind == KIND_LOAD);
            req_x_valid <= accept;
            req_y_valid <= accept;
            if (accept) begin
                busy      <= 1'b1;
                req_x_sel <= {instr_word[3:2], 1'b0, instr_word[1:0]};
                req_y_sel <= {instr_word[7:6], 1'b1, instr_word[5:4]};
                acc_out   <= acc_nxt;
                flag_z    <= z_nxt;
                flag_n    <= n_nxt;
            end else if (listen && both_in) begin
                busy  <= 1'b0;
                x_out <= x_new;
                y_out <= y_new;
            end
        end
    end
endmodule

// File: rtl/mac_seq_chk.sv
module mac_seq_chk #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              busy,
    input logic              anomaly,
    input logic              stat_hi_clr,
    input logic              req_x_valid,
    input logic              req_y_valid,
    input logic [DATA_W-1:0] x_out,
    input logic [DATA_W-1:0] y_out,
    input logic [ACC_W-1:0]  acc_out,
    input logic              flag_z,
    input logic              flag_n
);
    assert_acc_moves_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_out) |-> $rose(busy));

    assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hi_clr |-> (acc_out == '0 && !flag_z && !flag_n));

    assert_flags_follow_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !stat_hi_clr) |-> (flag_z == (acc_out == '0)) && (flag_n == acc_out[ACC_W-1]));

    assert_paired_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_x_valid == req_y_valid);

    assert_single_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_x_valid |=> !req_x_valid);

    assert_operands_on_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(x_out) || !$stable(y_out)) |-> $fell(busy));

    assert_busy_from_instr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_valid));

    assert_anomaly_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        anomaly |-> $rose(busy));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(acc_out));
endmodule

bind mac_operand_seq mac_seq_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
    .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .busy (busy),
    .anomaly (anomaly), .stat_hi_clr (stat_hi_clr),
    .req_x_valid (req_x_valid), .req_y_valid (req_y_valid),
    .x_out (x_out), .y_out (y_out), .acc_out (acc_out),
    .flag_z (flag_z), .flag_n (flag_n)
);

// File: tb/mac_operand_seq_tb_top.sv
module mac_operand_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        rsp_x_valid = 1'b0, rsp_y_valid = 1'b0;
    logic [15:0] rsp_x_data = '0, rsp_y_data = '0;
    logic        busy, anomaly, stat_hi_clr, req_x_valid, req_y_valid;
    logic [4:0]  req_x_sel, req_y_sel;
    logic [15:0] x_out, y_out;
    logic [31:0] acc_out;
    logic        flag_z, flag_n;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] e_acc = '0;
    logic [15:0] e_x = '0, e_y = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_operand_seq dut_i (
        .clk, .rst_n, .instr_valid, .instr_word, .busy, .anomaly, .stat_hi_clr,
        .req_x_valid, .req_x_sel, .rsp_x_valid, .rsp_x_data,
        .req_y_valid, .req_y_sel, .rsp_y_valid, .rsp_y_data,
        .x_out, .y_out, .acc_out, .flag_z, .flag_n
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sprod(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] sa, sb;
        sa = {{16{a[15]}}, a};
        sb = {{16{b[15]}}, b};
        return sa * sb;
    endfunction

    // opc: 7-bit opcode; b8: bit 8; xf/yf: {mod,idx} nibbles; dx/dy: response delay
    task automatic run_mac(input logic [6:0] opc, input logic b8,
                           input logic [3:0] xf, input logic [3:0] yf,
                           input logic [15:0] xd, input logic [15:0] yd,
                           input int dx, input int dy, input bit intrude);
        int last;
        logic [15:0] old_x, old_y;
        old_x = e_x; old_y = e_y;
        if (opc == 7'h4B)      e_acc = e_acc + sprod(e_x, e_y);
        else if (opc == 7'h1B) e_acc = e_acc - sprod(e_x, e_y);
        else                   e_acc = '0;
        @(negedge clk);
        instr_word  = {opc, b8, yf, xf};
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        check("R7 busy after start", {31'b0, busy}, 32'd1);
        check(opc == 7'h4B ? "R1 acc" : (opc == 7'h1B ? "R2 acc" : "R3 acc"), acc_out, e_acc);
        if (opc == 7'h5B) begin
            check("R3 flags cleared", {30'b0, flag_z, flag_n}, 32'd0);
            check("R3 stat_hi_clr pulse", {31'b0, stat_hi_clr}, 32'd1);
        end else begin
            check("R4 zero flag", {31'b0, flag_z}, {31'b0, e_acc == 32'd0});
            check("R4 neg flag", {31'b0, flag_n}, {31'b0, e_acc[31]});
            check("R3 no stat_hi_clr", {31'b0, stat_hi_clr}, 32'd0);
        end
        check("R8 anomaly", {31'b0, anomaly}, {31'b0, ~b8});
        check("R5 req valids", {30'b0, req_x_valid, req_y_valid}, 32'd3);
        check("R5 x sel", {27'b0, req_x_sel}, {27'b0, xf[3:2], 1'b0, xf[1:0]});
        check("R5 y sel", {27'b0, req_y_sel}, {27'b0, yf[3:2], 1'b1, yf[1:0]});
        last = (dx > dy) ? dx : dy;
        for (int k = 0; k <= last; k++) begin
            if (k > 0) begin
                check("R6 x held", {16'b0, x_out}, {16'b0, old_x});
                check("R7 busy held", {31'b0, busy}, 32'd1);
                check("R5 req single", {30'b0, req_x_valid, req_y_valid}, 32'd0);
                check("R8 anomaly single", {31'b0, anomaly}, 32'd0);
            end
            rsp_x_valid = (k == dx);
            rsp_x_data  = (k == dx) ? xd : 16'hDEAD;
            rsp_y_valid = (k == dy);
            rsp_y_data  = (k == dy) ? yd : 16'hBEEF;
            instr_valid = intrude && (k == 0);
            instr_word  = {7'h4B, 1'b1, 8'h00};
            @(negedge clk);
        end
        rsp_x_valid = 1'b0; rsp_y_valid = 1'b0; instr_valid = 1'b0;
        e_x = xd; e_y = yd;
        check("R7 busy fell", {31'b0, busy}, 32'd0);
        check("R6 x loaded", {16'b0, x_out}, {16'b0, e_x});
        check("R6 y loaded", {16'b0, y_out}, {16'b0, e_y});
        check(intrude ? "R9 acc unchanged while busy" : "R1 acc stable", acc_out, e_acc);
    endtask

    task automatic t_reset;
        check("R10 acc", acc_out, 32'd0);
        check("R10 x,y", {x_out, y_out}, 32'd0);
        check("R10 flags/busy", {27'b0, flag_z, flag_n, busy, anomaly, stat_hi_clr}, 32'd0);
        check("R10 reqs", {30'b0, req_x_valid, req_y_valid}, 32'd0);
    endtask

    task automatic t_unknown_opcode;
        @(negedge clk);
        instr_word  = {7'h4C, 1'b1, 8'h12};
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        check("R9 unknown opcode no busy", {31'b0, busy}, 32'd0);
        check("R9 unknown opcode acc", acc_out, e_acc);
        check("R9 unknown opcode no req", {31'b0, req_x_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        // load, Y late
        run_mac(7'h5B, 1'b1, 4'b0110, 4'b1001, 16'd3, 16'd5, 0, 2, 1'b0);
        // accumulate 3*5, X late
        run_mac(7'h4B, 1'b1, 4'b1111, 4'b0000, 16'hFFFE, 16'd7, 3, 1, 1'b0);
        // subtract -14, both same cycle
        run_mac(7'h1B, 1'b1, 4'b0001, 4'b1110, 16'h7FFF, 16'h8000, 1, 1, 1'b0);
        // subtract extreme product
        run_mac(7'h1B, 1'b1, 4'b1010, 4'b0101, 16'h8000, 16'h8000, 0, 0, 1'b0);
        // accumulate 0x40000000, bit 8 clear, intrusion while busy
        run_mac(7'h4B, 1'b0, 4'b0011, 4'b1100, 16'd2, 16'd3, 2, 0, 1'b1);
        // load then zero result: -6 then +6
        run_mac(7'h5B, 1'b1, 4'b0000, 4'b0000, 16'd2, 16'd3, 1, 0, 1'b0);
        run_mac(7'h1B, 1'b1, 4'b0000, 4'b0000, 16'd2, 16'd3, 0, 0, 1'b0);
        run_mac(7'h4B, 1'b1, 4'b0000, 4'b0000, 16'd1, 16'd1, 0, 1, 1'b0);
        check("R4 exact zero reached", {31'b0, flag_z}, 32'd1);
        t_unknown_opcode();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule